// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time from a requester and breaks it into memory-side transactions. A transfer is described by a start byte address, a byte count, a direction and, for stores, the bytes to store. No transaction crosses a line boundary. The first piece begins at the requested address and stops at the end of its line or at the end of the transfer, whichever comes first. Every later piece begins on a line boundary.

Each transaction is offered with a valid/ready handshake. The next piece is offered only after the current one completes: an acknowledge pulse completes a store, and a data-valid pulse with a full line completes a load. Loaded bytes are collected into a result buffer in transfer order. One cycle after the transfer finishes, a response pulse goes back to the requester if the requester asked for one.

A requester that arrives while a transfer is active is turned away, and the request is not queued. When the active transfer ends, that requester receives one retry pulse. A drain input asks the block to report when nothing is outstanding.

Top module: `dma_chunk_seq`

## Requirements
- R1: After reset `req_busy`, `mem_valid`, `rsp_valid` and `drain_done` are 0. A request with nonzero length sampled while idle is accepted, and `req_busy` is 1 in the next cycle. A request sampled while busy raises `req_refused` for exactly the next cycle. A refused request is not queued and causes no transaction.
- R2: If a request was refused during a transfer, `req_retry` pulses for one cycle, in the first cycle in which `req_busy` is 0 again. Otherwise `req_retry` stays 0. At most one retry pulse is given per completed transfer.
- R3: The first transaction of a transfer has `mem_line` = address / LINE_BYTES and `mem_off` = address mod LINE_BYTES. Its `mem_len` is min(length, LINE_BYTES - offset), so `mem_off + mem_len` never exceeds LINE_BYTES.
- R4: Each later transaction starts at start address + bytes completed so far. It has `mem_off` = 0 and `mem_len` = min(bytes remaining, LINE_BYTES). The transactions cover the transfer exactly, with no transaction left over.
- R5: `mem_valid` and its fields stay stable until `mem_ready` is sampled high. After that handshake, no further transaction is offered until the completion pulse: `mem_ack` for a store, `mem_rvalid` for a load.
- R6: In a store transaction, byte `mem_off + i` of `mem_wdata` (bits [8*(mem_off+i) +: 8]) carries request byte `done + i`, for i < `mem_len`. Here `done` is the number of bytes already completed. All other line bytes are 0.
- R7: For a load, result byte `done + i` takes line byte `mem_off + i` of `mem_rdata` on the completion pulse. Result bytes at or above the transfer length read as 0.
- R8: `rsp_valid` pulses for one cycle, exactly one cycle after the first cycle with `req_busy` low, and only when `req_need_rsp` was 1 at acceptance. `rsp_data` holds the gathered bytes for a load or the captured store bytes for a store.
- R9: `req_busy` is already 0 in the cycle after the completing pulse, so a request presented in that cycle is accepted.
- R10: `drain_done` is 1 exactly when `drain_req` was 1 at the last edge and no transfer is active. It stays 0 while a transfer is active and rises in the first idle cycle.
- R11: A request of length 0 raises `req_err` for the next cycle. It issues no transaction and leaves `req_busy` at 0. Lengths above MAX_LEN are not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store transfer, 0 = load transfer |
| req_need_rsp | input | 1 | Requester wants a response pulse |
| req_addr | input | AW | Start byte address |
| req_len | input | $clog2(MAX_LEN+1) | Transfer length in bytes |
| req_wdata | input | MAX_LEN*8 | Store bytes, byte k at bits [8k +: 8] |
| req_busy | output | 1 | A transfer is active |
| req_refused | output | 1 | Previous-cycle request was turned away |
| req_retry | output | 1 | One-cycle pulse telling a refused requester to try again |
| req_err | output | 1 | Previous-cycle request had zero length |
| mem_valid | output | 1 | Transaction offered |
| mem_ready | input | 1 | Memory side takes the transaction |
| mem_line | output | AW-log2(LINE_BYTES) | Line address |
| mem_off | output | log2(LINE_BYTES) | Byte offset within the line |
| mem_len | output | $clog2(LINE_BYTES+1) | Byte count of the transaction |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_wdata | output | LINE_BYTES*8 | Store line data |
| mem_ack | input | 1 | Store completion pulse |
| mem_rvalid | input | 1 | Load completion pulse |
| mem_rdata | input | LINE_BYTES*8 | Returned line |
| rsp_valid | output | 1 | Response pulse to the requester |
| rsp_write | output | 1 | Direction of the transfer being answered |
| rsp_data | output | MAX_LEN*8 | Gathered or stored bytes |
| drain_req | input | 1 | Drain requested |
| drain_done | output | 1 | Drain requested and nothing outstanding |

## Verification
- Accepting a request, refusing one and flagging a zero length each take one registered cycle, so `req_busy`, `req_refused` and `req_err` are read in the cycle after the request was sampled.
- Completion takes effect at the edge that samples the acknowledge or data pulse. `req_busy`, `req_retry` and `drain_done` change together in the next cycle. The response comes one cycle after that.
- A memory model in the bench checks every offered transaction against chunk lists computed with integer arithmetic when the request is made. The bench then advances and reads each flag, response and result buffer at the negative edge of the cycle in which it is due.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_LEN    = 64,
    localparam int OW = $clog2(LINE_BYTES),
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int CW = $clog2(LINE_BYTES + 1),
    localparam int LA = AW - OW
) (
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] done_bytes,
    input  logic [LW-1:0] total_bytes,
    output logic [LA-1:0] line_addr,
    output logic [OW-1:0] line_off,
    output logic [CW-1:0] piece_len
);
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] remain;
    logic [CW-1:0] room;

    always_comb begin
        cur_addr  = start_addr + AW'(done_bytes);
        line_off  = cur_addr[OW-1:0];
        line_addr = cur_addr[AW-1:OW];
        remain    = total_bytes - done_bytes;
        room      = CW'(LINE_BYTES) - CW'(line_off);
        piece_len = (int'(remain) < int'(room)) ? CW'(remain) : room;
    end
endmodule

// File: rtl/dma_line_pack.sv
module dma_line_pack #(
    parameter int LINE_BYTES = 16,
    parameter int MAX_LEN    = 64,
    localparam int OW = $clog2(LINE_BYTES),
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int CW = $clog2(LINE_BYTES + 1)
) (
    input  logic [MAX_LEN*8-1:0]    src_bytes,
    input  logic [OW-1:0]           line_off,
    input  logic [CW-1:0]           piece_len,
    input  logic [LW-1:0]           done_bytes,
    output logic [LINE_BYTES*8-1:0] line_data
);
    always_comb begin
        line_data = '0;
        for (int j = 0; j < LINE_BYTES; j++) begin
            int k;
            k = int'(done_bytes) + j - int'(line_off);
            if (j >= int'(line_off) && j < int'(line_off) + int'(piece_len) && k < MAX_LEN)
                line_data[j*8 +: 8] = src_bytes[k*8 +: 8];
        end
    end
endmodule

// File: rtl/dma_line_gather.sv
module dma_line_gather #(
    parameter int LINE_BYTES = 16,
    parameter int MAX_LEN    = 64,
    localparam int OW = $clog2(LINE_BYTES),
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int CW = $clog2(LINE_BYTES + 1)
) (
    input  logic [MAX_LEN*8-1:0]    acc_in,
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [OW-1:0]           line_off,
    input  logic [CW-1:0]           piece_len,
    input  logic [LW-1:0]           done_bytes,
    output logic [MAX_LEN*8-1:0]    acc_out
);
    always_comb begin
        acc_out = acc_in;
        for (int k = 0; k < MAX_LEN; k++) begin
            int s;
            s = k - int'(done_bytes) + int'(line_off);
            if (k >= int'(done_bytes) && k < int'(done_bytes) + int'(piece_len) && s < LINE_BYTES)
                acc_out[k*8 +: 8] = line_data[s*8 +: 8];
        end
    end
endmodule

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq
    import dma_chunk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_LEN    = 64,
    localparam int OW    = $clog2(LINE_BYTES),
    localparam int LW    = $clog2(MAX_LEN + 1),
    localparam int CW    = $clog2(LINE_BYTES + 1),
    localparam int LA    = AW - OW,
    localparam int LBITS = LINE_BYTES * 8,
    localparam int BBITS = MAX_LEN * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_need_rsp,
    input  logic [AW-1:0]    req_addr,
    input  logic [LW-1:0]    req_len,
    input  logic [BBITS-1:0] req_wdata,
    output logic             req_busy,
    output logic             req_refused,
    output logic             req_retry,
    output logic             req_err,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [LA-1:0]    mem_line,
    output logic [OW-1:0]    mem_off,
    output logic [CW-1:0]    mem_len,
    output logic             mem_write,
    output logic [LBITS-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_rvalid,
    input  logic [LBITS-1:0] mem_rdata,
    output logic             rsp_valid,
    output logic             rsp_write,
    output logic [BBITS-1:0] rsp_data,
    input  logic             drain_req,
    output logic             drain_done
);
    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    start;
        logic [LW-1:0]    total;
        logic             wr;
        logic             need;
        logic [LW-1:0]    issued;
        logic [LW-1:0]    done;
        logic [BBITS-1:0] data;
        logic             refused;
        logic             err;
        logic             retry;
        logic             pend;
        logic             fin;
        logic             rsp;
        logic             rsp_wr;
        logic [BBITS-1:0] rsp_data;
        logic             drained;
    } regs_t;

    regs_t q, d;

    logic [LA-1:0]    ch_line;
    logic [OW-1:0]    ch_off;
    logic [CW-1:0]    ch_len;
    logic [BBITS-1:0] gathered;
    logic             refuse_now;
    logic             piece_done;

    dma_chunk_calc #(.AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)) u_calc (
        .start_addr (q.start),
        .done_bytes (q.done),
        .total_bytes(q.total),
        .line_addr  (ch_line),
        .line_off   (ch_off),
        .piece_len  (ch_len)
    );

    dma_line_pack #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)) u_pack (
        .src_bytes (q.data),
        .line_off  (ch_off),
        .piece_len (ch_len),
        .done_bytes(q.done),
        .line_data (mem_wdata)
    );

    dma_line_gather #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)) u_gather (
        .acc_in    (q.data),
        .line_data (mem_rdata),
        .line_off  (ch_off),
        .piece_len (ch_len),
        .done_bytes(q.done),
        .acc_out   (gathered)
    );

    always_comb begin
        d          = q;
        d.err      = 1'b0;
        d.fin      = 1'b0;
        d.retry    = 1'b0;
        refuse_now = req_valid && (q.st != ST_IDLE);
        piece_done = q.wr ? mem_ack : mem_rvalid;

        // response follows the completion marker by one cycle
        d.rsp = q.fin & q.need;
        if (q.fin) begin
            d.rsp_wr   = q.wr;
            d.rsp_data = q.data;
        end

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_len == '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.st     = ST_ISSUE;
                        d.start  = req_addr;
                        d.total  = req_len;
                        d.wr     = req_write;
                        d.need   = req_need_rsp;
                        d.issued = '0;
                        d.done   = '0;
                        d.data   = req_write ? req_wdata : '0;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    d.issued = q.done + LW'(ch_len);
                    d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (piece_done) begin
                    if (!q.wr) d.data = gathered;
                    d.done = q.issued;
                    if (q.issued == q.total) begin
                        d.st  = ST_IDLE;
                        d.fin = 1'b1;
                    end else begin
                        d.st = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.refused = refuse_now;
        if (d.fin) begin
            d.retry = q.pend | refuse_now;
            d.pend  = 1'b0;
        end else begin
            d.pend = q.pend | refuse_now;
        end
        d.drained = drain_req && (d.st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_busy    = (q.st != ST_IDLE);
    assign req_refused = q.refused;
    assign req_retry   = q.retry;
    assign req_err     = q.err;
    assign mem_valid   = (q.st == ST_ISSUE);
    assign mem_line    = ch_line;
    assign mem_off     = ch_off;
    assign mem_len     = ch_len;
    assign mem_write   = q.wr;
    assign rsp_valid   = q.rsp;
    assign rsp_write   = q.rsp_wr;
    assign rsp_data    = q.rsp_data;
    assign drain_done  = q.drained;
endmodule

// File: rtl/dma_chunk_seq_chk.sv
module dma_chunk_seq_chk #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    localparam int OW = $clog2(LINE_BYTES),
    localparam int CW = $clog2(LINE_BYTES + 1),
    localparam int LA = AW - OW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_busy,
    input logic          req_refused,
    input logic          req_retry,
    input logic          req_err,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [LA-1:0] mem_line,
    input logic [OW-1:0] mem_off,
    input logic [CW-1:0] mem_len,
    input logic          rsp_valid,
    input logic          drain_done
);
    p_refuse_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && req_valid) |=> req_refused);

    p_refuse_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_refused |-> $past(req_busy));

    p_retry_at_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_retry |-> $fell(req_busy));

    p_piece_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((int'(mem_off) + int'(mem_len) <= LINE_BYTES) && (mem_len != '0)));

    p_offer_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_line) && $stable(mem_off) && $stable(mem_len)));

    p_rsp_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!req_busy));

    p_drain_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> !req_busy);

    p_zero_len_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!req_busy && !mem_valid));
endmodule

bind dma_chunk_seq dma_chunk_seq_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_busy   (req_busy),
    .req_refused(req_refused),
    .req_retry  (req_retry),
    .req_err    (req_err),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_line   (mem_line),
    .mem_off    (mem_off),
    .mem_len    (mem_len),
    .rsp_valid  (rsp_valid),
    .drain_done (drain_done)
);

// File: tb/sim_dma_chunk_seq.sv
module sim_dma_chunk_seq;
    localparam int AW = 32, LB = 16, ML = 64;
    localparam int OW = 4, LW = 7, CW = 5, LA = AW - OW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, req_valid, req_write, req_need_rsp;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic [ML*8-1:0] req_wdata;
    logic req_busy, req_refused, req_retry, req_err;
    logic mem_valid, mem_ready, mem_write, mem_ack, mem_rvalid;
    logic [LA-1:0] mem_line;
    logic [OW-1:0] mem_off;
    logic [CW-1:0] mem_len;
    logic [LB*8-1:0] mem_wdata, mem_rdata;
    logic rsp_valid, rsp_write, drain_req, drain_done;
    logic [ML*8-1:0] rsp_data;

    dma_chunk_seq u0 (.*);

    int tests = 0, fails = 0;
    int q_line[$], q_off[$], q_len[$], q_done[$], q_wr[$];
    int seed = 0;
    logic [ML*8-1:0] exp_res, exp_prev;

    function automatic int memb(int a); return (a * 7 + 3) & 255; endfunction
    function automatic int wbyte(int k, int s); return (k * 13 + s) & 255; endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chkv(bit ok, string req, string what, logic [ML*8-1:0] act, logic [ML*8-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // memory-side model
    int rs = 0, cnt = 0, txn = 0, rd_line = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rs = 0; cnt = 0; txn = 0;
            mem_ready = 0; mem_ack = 0; mem_rvalid = 0; mem_rdata = '0;
        end else begin
            case (rs)
                0: begin
                    mem_ack = 0; mem_rvalid = 0;
                    if (mem_valid) begin
                        if (q_line.size() == 0) begin
                            chk(0, "R4", "unexpected transaction", int'(mem_line), -1);
                        end else begin
                            int el, eo, en, ed, ew;
                            logic [LB*8-1:0] ex;
                            el = q_line.pop_front(); eo = q_off.pop_front();
                            en = q_len.pop_front(); ed = q_done.pop_front(); ew = q_wr.pop_front();
                            chk(int'(mem_line) == el, (ed == 0) ? "R3" : "R4", "line", int'(mem_line), el);
                            chk(int'(mem_off) == eo, (ed == 0) ? "R3" : "R4", "offset", int'(mem_off), eo);
                            chk(int'(mem_len) == en, (ed == 0) ? "R3" : "R4", "length", int'(mem_len), en);
                            chk(int'(mem_write) == ew, "R5", "direction", int'(mem_write), ew);
                            if (ew == 1) begin
                                ex = '0;
                                for (int j = 0; j < LB; j++)
                                    if (j >= eo && j < eo + en) ex[j*8 +: 8] = 8'(wbyte(ed + j - eo, seed));
                                chkv(mem_wdata == ex, "R6", "store line", ML*8'(mem_wdata), ML*8'(ex));
                            end
                        end
                        rd_line = int'(mem_line);
                        cnt = txn % 3;
                        if (cnt == 0) begin mem_ready = 1; rs = 2; end
                        else rs = 1;
                    end
                end
                1: begin
                    cnt--;
                    if (cnt == 0) begin mem_ready = 1; rs = 2; end
                end
                2: begin
                    mem_ready = 0; cnt = txn % 2; txn++; rs = 3;
                end
                3: begin
                    if (mem_valid) chk(0, "R5", "offer before completion", 1, 0);
                    if (cnt == 0) begin
                        if (mem_write) mem_ack = 1;
                        else begin
                            mem_rvalid = 1;
                            for (int j = 0; j < LB; j++) mem_rdata[j*8 +: 8] = 8'(memb(rd_line * LB + j));
                        end
                        rs = 4;
                    end else cnt--;
                end
                default: begin
                    mem_ack = 0; mem_rvalid = 0; rs = 0;
                end
            endcase
        end
    end

    task automatic drive_req(int addr, int len, bit wr, bit need);
        seed += 17;
        req_addr = AW'(addr); req_len = LW'(len); req_write = wr; req_need_rsp = need;
        for (int i = 0; i < ML; i++) req_wdata[i*8 +: 8] = 8'(wbyte(i, seed));
        exp_res = '0;
        for (int i = 0; i < ML; i++)
            if (wr) exp_res[i*8 +: 8] = 8'(wbyte(i, seed));
            else if (i < len) exp_res[i*8 +: 8] = 8'(memb(addr + i));
        begin
            int dn;
            dn = 0;
            while (dn < len) begin
                int cur, off, ch;
                cur = addr + dn; off = cur % LB;
                ch = (len - dn < LB - off) ? len - dn : LB - off;
                q_line.push_back(cur / LB); q_off.push_back(off); q_len.push_back(ch);
                q_done.push_back(dn); q_wr.push_back(int'(wr));
                dn += ch;
            end
        end
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(req_busy == 1, "R1", "busy after accept", int'(req_busy), 1);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (req_busy && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_req(bit need, bit exp_retry, bit is_wr);
        wait_idle();
        chk(req_retry == exp_retry, "R2", "retry at finish", int'(req_retry), int'(exp_retry));
        chk(q_line.size() == 0, "R4", "chunks left", q_line.size(), 0);
        chk(rsp_valid == 0, "R8", "rsp too early", int'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid == need, "R8", "rsp pulse", int'(rsp_valid), int'(need));
        if (need) chkv(rsp_data == exp_res, is_wr ? "R8" : "R7", "rsp data", rsp_data, exp_res);
        chk(req_retry == 0, "R2", "single retry", int'(req_retry), 0);
        @(negedge clk);
        chk(rsp_valid == 0, "R8", "rsp one cycle", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_need_rsp = 0;
        req_addr = '0; req_len = '0; req_wdata = '0; drain_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_busy == 0 && mem_valid == 0, "R1", "reset idle", int'(req_busy), 0);
        chk(rsp_valid == 0 && drain_done == 0, "R10", "reset outputs", int'(drain_done), 0);

        // aligned single-line load
        drive_req(32'h40, 16, 0, 1); finish_req(1, 0, 0);
        // unaligned load over three lines: 11, 16, 13
        drive_req(32'h105, 40, 0, 1); finish_req(1, 0, 0);
        // store inside one line
        drive_req(32'h23, 5, 1, 1); finish_req(1, 0, 1);
        // unaligned full-size store: 9,16,16,16,7
        drive_req(32'h37, 64, 1, 1); finish_req(1, 0, 1);
        // no response wanted
        drive_req(32'h80, 20, 0, 0); finish_req(0, 0, 0);
        // aligned max-length store
        drive_req(32'h300, 64, 1, 1); finish_req(1, 0, 1);

        // refusal while busy, then one retry
        drive_req(32'h201, 50, 0, 1);
        @(negedge clk);
        req_valid = 1; req_len = LW'(8);
        @(negedge clk);
        req_valid = 0;
        chk(req_refused == 1, "R1", "refused while busy", int'(req_refused), 1);
        chk(req_busy == 1, "R1", "still busy", int'(req_busy), 1);
        @(negedge clk);
        chk(req_refused == 0, "R1", "refuse one cycle", int'(req_refused), 0);
        finish_req(1, 1, 0);
        // following transfer gives no retry
        drive_req(32'h11, 3, 0, 1); finish_req(1, 0, 0);

        // back-to-back: new request in first idle cycle (R9)
        drive_req(32'h3c, 10, 0, 1);
        wait_idle();
        exp_prev = exp_res;
        drive_req(32'h90, 6, 1, 1);
        chk(req_busy == 1, "R9", "accept right after finish", int'(req_busy), 1);
        chk(rsp_valid == 1, "R8", "previous rsp", int'(rsp_valid), 1);
        chkv(rsp_data == exp_prev, "R7", "previous data", rsp_data, exp_prev);
        finish_req(1, 0, 1);

        // drain
        drain_req = 1;
        @(negedge clk);
        chk(drain_done == 1, "R10", "drain idle", int'(drain_done), 1);
        drive_req(32'h150, 30, 0, 1);
        chk(drain_done == 0, "R10", "drain deferred", int'(drain_done), 0);
        wait_idle();
        chk(drain_done == 1, "R10", "drain after finish", int'(drain_done), 1);
        @(negedge clk); @(negedge clk);
        drain_req = 0;
        @(negedge clk);
        chk(drain_done == 0, "R10", "drain released", int'(drain_done), 0);

        // zero length
        req_addr = AW'(32'h44); req_len = '0; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(req_err == 1, "R11", "zero-length error", int'(req_err), 1);
        chk(req_busy == 0 && mem_valid == 0, "R11", "no transfer", int'(req_busy), 0);
        @(negedge clk);
        chk(req_err == 0 && mem_valid == 0, "R11", "error one cycle", int'(req_err), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule